// File: doc/BRIEF.md
# Presettable Decade Counter Digit

This block is one synchronous BCD digit. It counts up from 0 to 9 and then returns to 0. A presettable counter like this serves as a single stage of a multi-digit decimal counter, or alone as a divide-by-ten timing stage. The state is a four-bit register. An active-low clear acts on it without waiting for a clock. The other two controls act on the rising clock edge: an active-low synchronous load that takes a four-bit value, and two count enables that must both be high before the digit advances.

The two enables have different roles. `en_count` only gates counting. `en_chain` gates counting and also qualifies the terminal flag `term`. To build a multi-digit counter, connect each digit's `term` to the `en_chain` input of the next digit up, and drive every `en_count` from a shared run signal. A higher digit then steps only on the cycle when every lower digit is at 9 and enabled.

The codes 10 to 15 are not part of the count. A load can still place one of them in the register. The next enabled count step then takes the digit straight to 0, so the counter never stays outside the decimal range while it runs.

Top module: `bcd_ctr`

## Requirements
- R1: With `clr_n` and `load_n` high and both enables high, a rising clock edge raises a count of 0 to 8 by exactly one.
- R2: Under the same enabled conditions, a count of 9 becomes 0 on the next rising edge.
- R3: While `clr_n` is low, `count` is 0 whatever the other inputs are. The clear takes effect as soon as `clr_n` falls, with no clock edge needed.
- R4: With `clr_n` high and `load_n` low, the next rising edge copies `load_val` into `count`. A load takes priority over counting and is not affected by the enables.
- R5: With `clr_n` and `load_n` high, if `en_count` or `en_chain` is low, `count` keeps its value across the edge.
- R6: `term` is high exactly when `count` equals 9 and `en_chain` is high. `en_count` has no effect on it.
- R7: When the register holds any code from 10 to 15 and an enabled count step occurs, the next value is 0.
- R8: A load accepts all sixteen four-bit codes, including 10 to 15, and `count` shows the loaded code unchanged until the next count step, load or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| load_val | input | 4 | Value taken by a load |
| en_count | input | 1 | Count enable that gates counting only |
| en_chain | input | 1 | Count enable that also qualifies `term` |
| count | output | 4 | Current BCD digit |
| term | output | 1 | Terminal flag: count is 9 and `en_chain` is high |

## Verification
On every cycle outside reset, the bound checker checks the following: increment and wrap, the load value arriving one edge after a load request, hold when either enable is low, the terminal flag, and the jump from an illegal code to 0. The asynchronous nature of the clear can only be shown by the bench. It drops `clr_n` in the middle of a cycle and looks at `count` before any edge arrives. The bench's scenarios also cover the priority of clear over a pending load, a load made while both enables are low, and the full 0 to 9 to 0 sequence.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;

    // Operation selected for the next clock edge (clear is handled asynchronously)
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } bcd_op_e;

endpackage

// File: rtl/bcd_ctr_ctrl.sv
module bcd_ctr_ctrl
    import bcd_ctr_pkg::*;
(
    input  logic    load_n,
    input  logic    en_count,
    input  logic    en_chain,
    output bcd_op_e op
);

    // Load wins over counting; counting needs both enables
    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (en_count && en_chain) begin
            op = OP_STEP;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/bcd_ctr_next.sv
module bcd_ctr_next
    import bcd_ctr_pkg::*;
#(
    parameter int DIGIT_W = 4,
    parameter int LAST    = 9
) (
    input  bcd_op_e              op,
    input  logic [DIGIT_W-1:0]   cur,
    input  logic [DIGIT_W-1:0]   load_val,
    output logic [DIGIT_W-1:0]   nxt
);

    localparam logic [DIGIT_W-1:0] LAST_V = DIGIT_W'(LAST);
    localparam logic [DIGIT_W-1:0] ONE_V  = DIGIT_W'(1);

    logic [DIGIT_W-1:0] stepped;

    // The last legal value and every illegal code fold back to zero
    always_comb begin
        if (cur >= LAST_V) begin
            stepped = '0;
        end else begin
            stepped = cur + ONE_V;
        end
    end

    always_comb begin
        case (op)
            OP_LOAD: nxt = load_val;
            OP_STEP: nxt = stepped;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/bcd_ctr_term.sv
module bcd_ctr_term #(
    parameter int DIGIT_W = 4,
    parameter int LAST    = 9
) (
    input  logic [DIGIT_W-1:0] cur,
    input  logic               en_chain,
    output logic               term
);

    localparam logic [DIGIT_W-1:0] LAST_V = DIGIT_W'(LAST);

    assign term = en_chain && (cur == LAST_V);

endmodule

// File: rtl/bcd_ctr.sv
module bcd_ctr
    import bcd_ctr_pkg::*;
#(
    parameter int DIGIT_W = 4,
    parameter int LAST    = 9
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic [DIGIT_W-1:0] load_val,
    input  logic               en_count,
    input  logic               en_chain,
    output logic [DIGIT_W-1:0] count,
    output logic               term
);

    typedef struct packed {
        logic [DIGIT_W-1:0] val;
    } state_t;

    state_t             st_d;
    state_t             st_q;
    bcd_op_e            op;
    logic [DIGIT_W-1:0] nxt_val;

    bcd_ctr_ctrl u_ctrl (
        .load_n   (load_n),
        .en_count (en_count),
        .en_chain (en_chain),
        .op       (op)
    );

    bcd_ctr_next #(
        .DIGIT_W (DIGIT_W),
        .LAST    (LAST)
    ) u_next (
        .op       (op),
        .cur      (st_q.val),
        .load_val (load_val),
        .nxt      (nxt_val)
    );

    bcd_ctr_term #(
        .DIGIT_W (DIGIT_W),
        .LAST    (LAST)
    ) u_term (
        .cur      (st_q.val),
        .en_chain (en_chain),
        .term     (term)
    );

    always_comb begin
        st_d     = st_q;
        st_d.val = nxt_val;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.val;

endmodule

// File: rtl/bcd_ctr_chk.sv
module bcd_ctr_chk #(
    parameter int DIGIT_W = 4,
    parameter int LAST    = 9
) (
    input logic               clk,
    input logic               clr_n,
    input logic               load_n,
    input logic [DIGIT_W-1:0] load_val,
    input logic               en_count,
    input logic               en_chain,
    input logic [DIGIT_W-1:0] count,
    input logic               term
);

    localparam logic [DIGIT_W-1:0] LAST_V = DIGIT_W'(LAST);
    localparam logic [DIGIT_W-1:0] ONE_V  = DIGIT_W'(1);

    logic run;
    assign run = load_n && en_count && en_chain;

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!clr_n)
        (run && count < LAST_V) |=> (count == $past(count) + ONE_V)); // R1

    AST_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
        (run && count == LAST_V) |=> (count == '0)); // R2

    always @(posedge clk) begin
        if (!clr_n) begin
            AST_CLEAR_ZERO: assert (count == '0); // R3
        end
    end

    AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (count == $past(load_val))); // R4

    AST_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_count && en_chain)) |=> $stable(count)); // R5

    AST_TERM_QUAL: assert property (@(posedge clk) disable iff (!clr_n)
        term |-> (en_chain && count == LAST_V)); // R6

    AST_TERM_SEEN: assert property (@(posedge clk) disable iff (!clr_n)
        (en_chain && count == LAST_V) |-> term); // R6

    AST_ILLEGAL_FOLD: assert property (@(posedge clk) disable iff (!clr_n)
        (run && count > LAST_V) |=> (count == '0)); // R7

endmodule

bind bcd_ctr bcd_ctr_chk #(
    .DIGIT_W (DIGIT_W),
    .LAST    (LAST)
) u_chk (
    .clk      (clk),
    .clr_n    (clr_n),
    .load_n   (load_n),
    .load_val (load_val),
    .en_count (en_count),
    .en_chain (en_chain),
    .count    (count),
    .term     (term)
);

// File: tb/bcd_ctr_tb.sv
module bcd_ctr_tb;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] load_val = 4'd0;
    logic       en_count = 1'b0;
    logic       en_chain = 1'b0;
    logic [3:0] count;
    logic       term;

    int         checks = 0;
    int         errors = 0;
    logic [4:0] exp_q[$];
    string      tag_q[$];
    logic [3:0] model = 4'd0;

    always #4 clk = ~clk;

    bcd_ctr u_dut (
        .clk      (clk),
        .clr_n    (clr_n),
        .load_n   (load_n),
        .load_val (load_val),
        .en_count (en_count),
        .en_chain (en_chain),
        .count    (count),
        .term     (term)
    );

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s count/term actual %0d/%0b expected %0d/%0b",
                     tag, act[4:1], act[0], exp[4:1], exp[0]);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected result
    task automatic step(input logic c, input logic l, input logic [3:0] v,
                        input logic e1, input logic e2, input string tag);
        @(negedge clk);
        clr_n = c; load_n = l; load_val = v; en_count = e1; en_chain = e2;
        if (!c) model = 4'd0;
        else if (!l) model = v;
        else if (e1 && e2) model = (model >= 4'd9) ? 4'd0 : model + 4'd1;
        exp_q.push_back({model, (model == 4'd9) && e2});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare after each edge, before inputs move again
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), {count, term}, exp_q.pop_front());
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3;
        check("R3 reset state", {count, term}, 5'd0);
        step(0, 0, 4'd7, 1, 1, "R3 clear beats load");
        step(0, 1, 4'd0, 1, 1, "R3 clear beats count");
        // Full run through the decade, R1 then R2 wrap
        for (int i = 0; i < 9; i++) step(1, 1, 4'd0, 1, 1, "R1 increment");
        step(1, 1, 4'd0, 1, 1, "R2 wrap to zero");
        step(1, 1, 4'd0, 1, 1, "R1 increment after wrap");
        // Load overrides enables, R4
        step(1, 0, 4'd9, 0, 0, "R4 load with enables low");
        step(1, 1, 4'd0, 0, 1, "R5 hold en_count low; R6 term high");
        step(1, 1, 4'd0, 1, 0, "R5 hold en_chain low; R6 term low");
        step(1, 0, 4'd3, 1, 1, "R4 load beats count");
        step(1, 1, 4'd0, 1, 1, "R1 increment from loaded value");
        // Illegal codes, R8 and R7
        step(1, 0, 4'd12, 1, 1, "R8 load illegal 12");
        step(1, 1, 4'd0, 0, 1, "R8 illegal 12 held, term low");
        step(1, 1, 4'd0, 1, 1, "R7 illegal 12 folds to zero");
        step(1, 0, 4'd15, 1, 1, "R8 load illegal 15");
        step(1, 1, 4'd0, 1, 1, "R7 illegal 15 folds to zero");
        step(1, 0, 4'd10, 1, 1, "R8 load illegal 10");
        step(1, 1, 4'd0, 1, 1, "R7 illegal 10 folds to zero");
        step(1, 0, 4'd8, 1, 1, "R4 load 8");
        step(1, 1, 4'd0, 1, 1, "R1 8 to 9; R6 term high");
        // Asynchronous clear mid-cycle, R3
        @(negedge clk);
        #2;
        clr_n = 1'b0;
        #1;
        check("R3 async clear without edge", {count, term}, 5'd0);
        model = 4'd0;
        step(0, 1, 4'd0, 1, 1, "R3 clear held");
        step(1, 1, 4'd0, 1, 1, "R1 count resumes after clear");
        @(negedge clk);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule